// File: doc/BRIEF.md
# Modem Handshake Line Controller

This block drives and monitors the modem handshake lines of a serial port. Software writes a six-bit control word. The low four bits drive the four handshake outputs directly. Bit 4 turns the port into an internal loopback. Bit 5 enables automatic hardware flow control.

The four handshake inputs are clear-to-send, data-set-ready, ring indicator and carrier detect. Each one is resynchronised to the local clock. Each produces a level bit and a latched change bit in an eight-bit status byte. Any latched change raises the modem-status interrupt request, and an acknowledge pulse clears all change bits.

When automatic flow control is on, the block does two things. It holds back the transmitter while clear-to-send is inactive. It withdraws request-to-send while free space in the receive buffer is below a fixed margin.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset, all four handshake outputs are 0, the status byte is 0x00, the interrupt request is 0 and the transmit permission is 1.
- R2: A control write with bit 4 and bit 5 clear drives the handshake outputs in the next cycle: bit 0 drives dtr_o, bit 1 drives rts_o, bit 2 drives out1_o and bit 3 drives out2_o.
- R3: The status byte reports the input levels in bits 4 (CTS), 5 (DSR), 6 (RI) and 7 (DCD). A change on an external input appears there after two clock edges, which is the synchroniser depth.
- R4: For CTS, DSR and DCD, either edge of the level sets the matching change bit (bits 0, 1 and 3). The change bit is set one clock edge after the level bit changes.
- R5: The RI change bit (bit 2) is set only when the RI level falls from 1 to 0. A rising RI leaves it clear.
- R6: Change bits stay set until ms_ack_i is sampled high, and that acknowledge clears all of them. A change that is detected on the same edge as the acknowledge stays set.
- R7: ms_irq_o is 1 exactly when at least one change bit is set.
- R8: In loopback mode (control bit 4), the levels come from the control bits instead of the pins: RTS feeds CTS, DTR feeds DSR, OUT1 feeds RI and OUT2 feeds DCD. All four handshake outputs are held at 0, and the external inputs are ignored.
- R9: With automatic flow control on (control bit 5), tx_allow_o follows the CTS level bit. With it off, tx_allow_o is 1.
- R10: With automatic flow control on, rts_o is 0 in any cycle after an edge that sampled rx_free_i below RTS_MARGIN. Otherwise rts_o follows control bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 6 | Control word: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback, bit 5 automatic flow control |
| cts_i | input | 1 | Clear-to-send input, active high, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, active high, asynchronous |
| ri_i | input | 1 | Ring indicator input, active high, asynchronous |
| dcd_i | input | 1 | Carrier detect input, active high, asynchronous |
| ms_ack_i | input | 1 | Modem-status interrupt acknowledge, clears change bits |
| rx_free_i | input | FREE_W | Free entries in the receive buffer |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| msr_o | output | 8 | Status byte: [3:0] change bits, [7:4] levels (CTS, DSR, RI, DCD) |
| ms_irq_o | output | 1 | Modem-status interrupt request |
| tx_allow_o | output | 1 | Transmitter may start a new character |

## Verification
The properties assume that reset starts with all external handshake inputs low. This keeps the first synchronised sample from being counted as a change. They also assume that rx_free_i and ms_ack_i are settled before each edge. The stimulus drives every input just after a falling clock edge. It holds the pins at 0 through reset, and it pulses the acknowledge for exactly one cycle. Because of this, each change bit can be traced to one level transition that the properties can see in the status byte.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  typedef struct packed {
    logic afc;
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mctl_t;

  localparam int unsigned CTRL_W = $bits(mctl_t);
  localparam int unsigned N_LINES = 4;
  // line index inside the status byte nibbles
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;
  localparam logic [N_LINES-1:0] TRAIL_ONLY = N_LINES'(1) << LN_RI;
endpackage

// File: rtl/mcu_sync.sv
module mcu_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[0] <= '0;
        else         stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mcu_delta.sv
module mcu_delta #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TRAIL_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         ack_i,
  output logic [W-1:0] delta_o
);
  logic [W-1:0] prev_q, delta_q, evt;

  for (genvar i = 0; i < W; i++) begin : g_evt
    if (TRAIL_MASK[i]) begin : g_fall
      assign evt[i] = prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign evt[i] = prev_q[i] ^ lvl_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= lvl_i;
      // fresh events survive a coincident acknowledge
      delta_q <= (ack_i ? '0 : delta_q) | evt;
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/mcu_flow.sv
module mcu_flow #(
  parameter int unsigned FREE_W     = 11,
  parameter int unsigned RTS_MARGIN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              afc_i,
  input  logic              cts_lvl_i,
  input  logic [FREE_W-1:0] rx_free_i,
  output logic              rts_gate_o,
  output logic              tx_allow_o
);
  localparam logic [FREE_W-1:0] MARGIN = FREE_W'(RTS_MARGIN);

  logic room_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) room_q <= 1'b1;
    else         room_q <= (rx_free_i >= MARGIN);
  end

  assign rts_gate_o = ~afc_i | room_q;
  assign tx_allow_o = ~afc_i | cts_lvl_i;
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import mcu_pkg::*;
#(
  parameter int unsigned FREE_W      = 11,
  parameter int unsigned RTS_MARGIN  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [5:0]        cfg_wdata_i,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  input  logic              ms_ack_i,
  input  logic [FREE_W-1:0] rx_free_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o,
  output logic [7:0]        msr_o,
  output logic              ms_irq_o,
  output logic              tx_allow_o
);
  mctl_t ctrl_q;
  logic [N_LINES-1:0] pin_in, pin_sync, lvl, loop_src, delta;
  logic rts_gate;
  logic loop_en, afc_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (cfg_wr_i) ctrl_q <= mctl_t'(cfg_wdata_i);
  end

  assign loop_en = ctrl_q.loop;
  assign afc_en  = ctrl_q.afc;

  assign pin_in[LN_CTS] = cts_i;
  assign pin_in[LN_DSR] = dsr_i;
  assign pin_in[LN_RI]  = ri_i;
  assign pin_in[LN_DCD] = dcd_i;

  assign loop_src[LN_CTS] = ctrl_q.rts;
  assign loop_src[LN_DSR] = ctrl_q.dtr;
  assign loop_src[LN_RI]  = ctrl_q.out1;
  assign loop_src[LN_DCD] = ctrl_q.out2;

  mcu_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in),
    .q_o    (pin_sync)
  );

  assign lvl = loop_en ? loop_src : pin_sync;

  mcu_delta #(.W(N_LINES), .TRAIL_MASK(TRAIL_ONLY)) u_delta (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .ack_i   (ms_ack_i),
    .delta_o (delta)
  );

  mcu_flow #(.FREE_W(FREE_W), .RTS_MARGIN(RTS_MARGIN)) u_flow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .afc_i      (afc_en),
    .cts_lvl_i  (lvl[LN_CTS]),
    .rx_free_i  (rx_free_i),
    .rts_gate_o (rts_gate),
    .tx_allow_o (tx_allow_o)
  );

  assign dtr_o  = ctrl_q.dtr  & ~loop_en;
  assign rts_o  = ctrl_q.rts  & ~loop_en & rts_gate;
  assign out1_o = ctrl_q.out1 & ~loop_en;
  assign out2_o = ctrl_q.out2 & ~loop_en;

  assign msr_o    = {lvl, delta};
  assign ms_irq_o = |delta;
endmodule

// File: rtl/mcu_checker.sv
module mcu_checker #(
  parameter int unsigned FREE_W     = 11,
  parameter int unsigned RTS_MARGIN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ms_ack_i,
  input logic [FREE_W-1:0] rx_free_i,
  input logic              dtr_o,
  input logic              rts_o,
  input logic              out1_o,
  input logic              out2_o,
  input logic [7:0]        msr_o,
  input logic              ms_irq_o,
  input logic              tx_allow_o,
  input logic              loop_en,
  input logic              afc_en
);
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ms_ack_i |=> ((msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0])));

  assert_ack_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_ack_i && $stable(msr_o[7:4])) |=> !ms_irq_o);

  assert_cts_delta_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msr_o[0]) |-> ($past(msr_o[4]) != $past(msr_o[4], 2)));

  assert_ri_trailing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msr_o[2]) |-> ($past(msr_o[6], 2) && !$past(msr_o[6])));

  assert_loop_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en |-> !(dtr_o || rts_o || out1_o || out2_o));

  assert_tx_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_allow_o |-> (afc_en && !msr_o[4]));

  assert_rts_room_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (afc_en && $past(afc_en) && ($past(rx_free_i) < FREE_W'(RTS_MARGIN))) |-> !rts_o);
endmodule

bind modem_ctl_unit mcu_checker #(.FREE_W(FREE_W), .RTS_MARGIN(RTS_MARGIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ms_ack_i   (ms_ack_i),
  .rx_free_i  (rx_free_i),
  .dtr_o      (dtr_o),
  .rts_o      (rts_o),
  .out1_o     (out1_o),
  .out2_o     (out2_o),
  .msr_o      (msr_o),
  .ms_irq_o   (ms_irq_o),
  .tx_allow_o (tx_allow_o),
  .loop_en    (loop_en),
  .afc_en     (afc_en)
);

// File: tb/modem_ctl_unit_test.sv
module modem_ctl_unit_test;
  localparam int unsigned FREE_W = 11;
  localparam int unsigned MARGIN = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_wr_i = 1'b0;
  logic [5:0] cfg_wdata_i = '0;
  logic cts_i = 1'b0, dsr_i = 1'b0, ri_i = 1'b0, dcd_i = 1'b0;
  logic ms_ack_i = 1'b0;
  logic [FREE_W-1:0] rx_free_i = FREE_W'(100);
  logic dtr_o, rts_o, out1_o, out2_o, ms_irq_o, tx_allow_o;
  logic [7:0] msr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  modem_ctl_unit #(.FREE_W(FREE_W), .RTS_MARGIN(MARGIN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
    .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i), .ms_ack_i(ms_ack_i),
    .rx_free_i(rx_free_i), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o),
    .out2_o(out2_o), .msr_o(msr_o), .ms_irq_o(ms_irq_o), .tx_allow_o(tx_allow_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [5:0] v);
    cfg_wr_i = 1'b1;
    cfg_wdata_i = v;
    step(1);
    cfg_wr_i = 1'b0;
  endtask

  task automatic ack();
    ms_ack_i = 1'b1;
    step(1);
    ms_ack_i = 1'b0;
  endtask

  task automatic set_pin(input int i, input logic v);
    case (i)
      0: cts_i = v;
      1: dsr_i = v;
      2: ri_i = v;
      default: dcd_i = v;
    endcase
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 outputs", {dtr_o, rts_o, out1_o, out2_o}, 0);
    chk("R1 msr", msr_o, 8'h00);
    chk("R1 irq", ms_irq_o, 0);
    chk("R1 tx_allow", tx_allow_o, 1);

    // R2 sweep of all output patterns
    for (int p = 0; p < 16; p++) begin
      write_cfg(6'(p));
      chk("R2 outputs", {out2_o, out1_o, rts_o, dtr_o}, 32'(p));
      chk("R2 no status change", msr_o, 8'h00);
    end
    write_cfg(6'h00);

    // R3/R4/R5 per-line edges
    for (int i = 0; i < 4; i++) begin
      set_pin(i, 1'b1);
      step(1);
      chk("R3 level not before sync", msr_o, 8'h00);
      step(1);
      chk("R3 level rise", msr_o[7:4], 32'(1 << i));
      chk("R4 delta one edge later", msr_o[3:0], 0);
      step(1);
      if (i == 2) chk("R5 no delta on RI rise", msr_o[3:0], 0);
      else        chk("R4 delta on rise", msr_o[3:0], 32'(1 << i));
      chk("R7 irq on rise", ms_irq_o, (i == 2) ? 0 : 1);
      step(4);
      if (i != 2) chk("R6 sticky", msr_o[3:0], 32'(1 << i));
      ack();
      chk("R6 ack clears", msr_o[3:0], 0);
      chk("R7 irq after ack", ms_irq_o, 0);
      set_pin(i, 1'b0);
      step(2);
      chk("R3 level fall", msr_o[7:4], 0);
      step(1);
      if (i == 2) chk("R5 delta on RI fall", msr_o[3:0], 32'h4);
      else        chk("R4 delta on fall", msr_o[3:0], 32'(1 << i));
      ack();
    end

    // R6 coincident change and acknowledge
    dsr_i = 1'b1;
    step(3);
    chk("R6 setup dsr delta", msr_o[3:0], 32'h2);
    cts_i = 1'b1;
    step(2);
    ms_ack_i = 1'b1;
    step(1);
    ms_ack_i = 1'b0;
    chk("R6 coincident delta kept", msr_o[3:0], 32'h1);
    chk("R7 irq kept", ms_irq_o, 1);
    ack();
    chk("R7 irq cleared", ms_irq_o, 0);

    // R8 loopback sweep, external pins opposite
    for (int p = 0; p < 16; p++) begin
      logic [3:0] exp_lvl;
      exp_lvl = {p[3], p[2], p[0], p[1]};
      {dcd_i, ri_i, dsr_i, cts_i} = ~exp_lvl;
      write_cfg(6'h10 | 6'(p));
      step(2);
      chk("R8 loop levels", msr_o[7:4], 32'(exp_lvl));
      chk("R8 outputs held", {dtr_o, rts_o, out1_o, out2_o}, 0);
      ack();
    end
    {dcd_i, ri_i, dsr_i, cts_i} = 4'h0;
    write_cfg(6'h00);
    step(3);
    ack();
    chk("R8 exit clean", msr_o, 8'h00);

    // R9 transmit gating
    chk("R9 allow when off", tx_allow_o, 1);
    write_cfg(6'h22);
    chk("R9 cts low gates", tx_allow_o, 0);
    cts_i = 1'b1;
    step(2);
    chk("R9 cts high allows", tx_allow_o, 1);
    cts_i = 1'b0;
    step(2);
    chk("R9 cts low again", tx_allow_o, 0);
    ack();

    // R10 threshold sweep around margin
    for (int f = MARGIN - 4; f <= MARGIN + 4; f++) begin
      rx_free_i = FREE_W'(f);
      step(1);
      chk("R10 rts vs room", rts_o, (f >= MARGIN) ? 1 : 0);
    end
    rx_free_i = FREE_W'(MARGIN - 1);
    write_cfg(6'h20);
    chk("R10 rts bit low", rts_o, 0);
    write_cfg(6'h02);
    chk("R10 no gating when off", rts_o, 1);
    chk("R9 allow when off again", tx_allow_o, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule